// File: doc/BRIEF.md
# Pipeline Load-Use Hazard Controller

This block is the hazard control for a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. Operands are read in decode and results are written back in writeback. Each cycle the block is given the instruction now in decode: a valid flag, its destination register and its two source registers. It keeps its own record of the destination register held by each older instruction in execute, memory and writeback, and it advances that record on every clock edge.

From those comparisons it raises a single stall. The stall holds the program counter and the fetch/decode register, and it makes the decode/execute register load an empty slot. For each decode operand it also picks a bypass multiplexer input. In the bypassing variant, a result becomes available at the end of the memory stage and can be steered straight into the decode operand. A load followed at once by its consumer therefore costs one stall cycle. With bypassing switched off by parameter, the consumer waits three cycles, until the producer has been written back.

Top module: `hazard_ctrl`

## Requirements
- R1: After reset no older instruction is recorded, so a valid decode instruction raises no stall and both operand selects read 0 (register file).
- R2: A valid decode instruction whose source equals the destination of the instruction in execute raises hold_pc, hold_fd and bubble_de together in that cycle, and all three are equal in every cycle.
- R3: With bypassing, a source matching the instruction in memory raises no stall and selects 1 (memory-stage value).
- R4: With bypassing, a source matching only the instruction in writeback raises no stall and selects 2 (writeback-stage value).
- R5: A source matching no older instruction selects 0 (register file).
- R6: When both the memory and the writeback instruction write the source register, the select is 1: the younger producer wins.
- R7: Register number NONE_REG (default 15) means "no register". It never counts as a dependency, whether it appears as a source or as a destination.
- R8: The slot that enters execute during a stall carries no destination. A load followed directly by its consumer therefore stalls exactly one cycle, and the consumer then selects 1.
- R9: A decode slot with dec_valid low raises no stall and leaves no destination behind for later instructions.
- R10: With bypassing disabled (FWD_EN = 0), a source matching execute, memory or writeback stalls. A load followed by its consumer stalls exactly three cycles, and both selects stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_dst | input | REG_W | Destination register of the decode instruction |
| dec_src_a | input | REG_W | First source register of the decode instruction |
| dec_src_b | input | REG_W | Second source register of the decode instruction |
| hold_pc | output | 1 | Keep the program counter this cycle |
| hold_fd | output | 1 | Keep the fetch/decode register this cycle |
| bubble_de | output | 1 | Load an empty slot into the decode/execute register |
| fwd_sel_a | output | 2 | Bypass select for operand A: 0 register file, 1 memory, 2 writeback |
| fwd_sel_b | output | 2 | Bypass select for operand B, same encoding |

## Verification
The stall, the bubble and both selects are combinational in the current decode inputs and the recorded stage contents, so each result is due in the same cycle the decode inputs are presented. The recorded destinations move one stage per rising edge. A producer that entered decode in cycle n is therefore seen in execute at n+1, in memory at n+2 and in writeback at n+3, and it has left at n+4. The bench changes inputs just after a falling edge and samples one nanosecond later, so every result is read after it settles and before the next rising edge. While a stall is reported, the bench keeps the stalled instruction on the decode inputs, which is what the held fetch/decode register would do.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_REGFILE = 2'd0,
      SEL_MEM     = 2'd1,
      SEL_WB      = 2'd2
   } fwd_src_e;
endpackage

// File: rtl/hz_dest_track.sv
module hz_dest_track #(
   parameter int REG_W    = 4,
   parameter int NONE_REG = 15,
   parameter int DEPTH    = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ins_valid,
   input  logic [REG_W-1:0]            ins_dst,
   output logic [DEPTH-1:0][REG_W-1:0] stage_dst
);
   localparam logic [REG_W-1:0] NONE_V = REG_W'(NONE_REG);

   initial begin
      assert (DEPTH >= 1) else $error("tracker depth must be at least 1");
   end

   // slot entering execute: empty when the decode slot is not advancing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_dst[0] <= NONE_V;
      else        stage_dst[0] <= ins_valid ? ins_dst : NONE_V;
   end

   for (genvar s = 1; s < DEPTH; s++) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_dst[s] <= NONE_V;
         else        stage_dst[s] <= stage_dst[s-1];
      end
   end
endmodule

// File: rtl/hz_match.sv
module hz_match #(
   parameter int REG_W    = 4,
   parameter int NONE_REG = 15
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   output logic             hit
);
   localparam logic [REG_W-1:0] NONE_V = REG_W'(NONE_REG);
   always_comb hit = (src != NONE_V) && (src == dst);
endmodule

// File: rtl/hz_operand.sv
module hz_operand
   import hz_pkg::*;
#(
   parameter int REG_W    = 4,
   parameter int NONE_REG = 15,
   parameter bit FWD_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] ex_dst,
   input  logic [REG_W-1:0] mem_dst,
   input  logic [REG_W-1:0] wb_dst,
   output logic             need_stall,
   output fwd_src_e         sel
);
   localparam logic [REG_W-1:0] NONE_V = REG_W'(NONE_REG);

   logic hit_ex, hit_mem, hit_wb;

   hz_match #(.REG_W(REG_W), .NONE_REG(NONE_REG)) u_m_ex
      (.src(src), .dst(ex_dst),  .hit(hit_ex));
   hz_match #(.REG_W(REG_W), .NONE_REG(NONE_REG)) u_m_mem
      (.src(src), .dst(mem_dst), .hit(hit_mem));
   hz_match #(.REG_W(REG_W), .NONE_REG(NONE_REG)) u_m_wb
      (.src(src), .dst(wb_dst),  .hit(hit_wb));

   if (FWD_EN) begin : g_bypass
      // execute result is not ready until the end of memory: wait one cycle
      always_comb begin
         need_stall = dec_valid && hit_ex;
         if (hit_mem)     sel = SEL_MEM;   // youngest producer first
         else if (hit_wb) sel = SEL_WB;
         else             sel = SEL_REGFILE;
      end

      a_r6_youngest_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == SEL_WB) |-> (mem_dst != src && wb_dst == src));
      a_r3_mem_source_matches: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == SEL_MEM) |-> (mem_dst == src));
   end else begin : g_wait
      // value visible only through the register file after writeback
      always_comb begin
         need_stall = dec_valid && (hit_ex || hit_mem || hit_wb);
         sel        = SEL_REGFILE;
      end
   end

   a_r7_none_never_hazard: assert property (@(posedge clk) disable iff (!rst_n)
      (src == NONE_V) |-> (!need_stall && sel == SEL_REGFILE));
   a_r9_invalid_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !need_stall);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
   import hz_pkg::*;
#(
   parameter int REG_W    = 4,
   parameter int NONE_REG = 15,
   parameter bit FWD_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [REG_W-1:0] dec_dst,
   input  logic [REG_W-1:0] dec_src_a,
   input  logic [REG_W-1:0] dec_src_b,
   output logic             hold_pc,
   output logic             hold_fd,
   output logic             bubble_de,
   output logic [1:0]       fwd_sel_a,
   output logic [1:0]       fwd_sel_b
);
   localparam int NUM_SRC = 2;
   localparam int DEPTH   = 3;   // execute, memory, writeback
   localparam int ST_EX   = 0;
   localparam int ST_MEM  = 1;
   localparam int ST_WB   = 2;
   localparam logic [REG_W-1:0] NONE_V = REG_W'(NONE_REG);

   initial begin
      assert (REG_W >= 1) else $error("REG_W must be positive");
      assert (NONE_REG >= 0 && NONE_REG < (1 << REG_W))
         else $error("NONE_REG must fit in REG_W bits");
   end

   logic [DEPTH-1:0][REG_W-1:0] stage_dst;
   logic [NUM_SRC-1:0][REG_W-1:0] srcs;
   logic [NUM_SRC-1:0]            op_stall;
   fwd_src_e                      op_sel [NUM_SRC];
   logic                          stall;

   assign srcs[0] = dec_src_a;
   assign srcs[1] = dec_src_b;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
      hz_operand #(.REG_W(REG_W), .NONE_REG(NONE_REG), .FWD_EN(FWD_EN)) u_op (
         .clk       (clk),
         .rst_n     (rst_n),
         .dec_valid (dec_valid),
         .src       (srcs[i]),
         .ex_dst    (stage_dst[ST_EX]),
         .mem_dst   (stage_dst[ST_MEM]),
         .wb_dst    (stage_dst[ST_WB]),
         .need_stall(op_stall[i]),
         .sel       (op_sel[i])
      );
   end

   always_comb begin
      stall     = |op_stall;
      hold_pc   = stall;
      hold_fd   = stall;
      bubble_de = stall;
      fwd_sel_a = op_sel[0];
      fwd_sel_b = op_sel[1];
   end

   hz_dest_track #(.REG_W(REG_W), .NONE_REG(NONE_REG), .DEPTH(DEPTH)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_valid(dec_valid && !stall),
      .ins_dst  (dec_dst),
      .stage_dst(stage_dst)
   );

   a_r8_bubble_empties_ex: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_de |=> (stage_dst[ST_EX] == NONE_V));
   a_r8_bubble_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_de |=> ##1 (stage_dst[ST_MEM] == NONE_V));

   if (FWD_EN) begin : g_chk_bypass
      a_r8_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
         hold_pc |=> !hold_pc);
   end
endmodule

// File: tb/tb_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_hazard_ctrl;
   localparam int REG_W = 4;
   localparam logic [3:0] NR = 4'd15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic v = 1'b0;
   logic [3:0] dst = NR, sa = NR, sb = NR;

   logic hp, hf, bd, nhp, nhf, nbd;
   logic [1:0] sel_a, sel_b, nsel_a, nsel_b;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   hazard_ctrl #(.REG_W(REG_W), .NONE_REG(15), .FWD_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .dec_valid(v), .dec_dst(dst),
      .dec_src_a(sa), .dec_src_b(sb), .hold_pc(hp), .hold_fd(hf),
      .bubble_de(bd), .fwd_sel_a(sel_a), .fwd_sel_b(sel_b));

   hazard_ctrl #(.REG_W(REG_W), .NONE_REG(15), .FWD_EN(1'b0)) dut_nf (
      .clk(clk), .rst_n(rst_n), .dec_valid(v), .dec_dst(dst),
      .dec_src_a(sa), .dec_src_b(sb), .hold_pc(nhp), .hold_fd(nhf),
      .bubble_de(nbd), .fwd_sel_a(nsel_a), .fwd_sel_b(nsel_b));

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // present a decode slot just after a falling edge, settle 1 ns
   task automatic put(logic vv, logic [3:0] d, logic [3:0] a, logic [3:0] b);
      @(negedge clk);
      v = vv; dst = d; sa = a; sb = b;
      #1;
   endtask

   task automatic expect_f(string req, int st, int ea, int eb);
      chk(req, "hold_pc", int'(hp), st);
      chk(req, "hold_fd", int'(hf), st);
      chk(req, "bubble_de", int'(bd), st);
      chk(req, "fwd_sel_a", int'(sel_a), ea);
      chk(req, "fwd_sel_b", int'(sel_b), eb);
   endtask

   task automatic expect_n(string req, int st, int ea, int eb);
      chk(req, "nf hold_pc", int'(nhp), st);
      chk(req, "nf hold_fd", int'(nhf), st);
      chk(req, "nf bubble_de", int'(nbd), st);
      chk(req, "nf fwd_sel_a", int'(nsel_a), ea);
      chk(req, "nf fwd_sel_b", int'(nsel_b), eb);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; v = 1'b0; dst = NR; sa = NR; sb = NR;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset();
      put(1'b1, 4'd2, 4'd1, 4'd0);
      expect_f("R1", 0, 0, 0);
      expect_n("R1", 0, 0, 0);
   endtask

   task automatic t_load_use();
      do_reset();
      put(1'b1, 4'd1, NR, NR);          // load r1
      expect_f("R1", 0, 0, 0);
      put(1'b1, 4'd6, 4'd1, NR);        // consumer, load in execute
      expect_f("R2", 1, 0, 0);
      put(1'b1, 4'd6, 4'd1, NR);        // held, load now in memory
      expect_f("R8", 0, 1, 0);
      put(1'b1, NR, 4'd1, 4'd6);        // load in writeback, r6 in execute
      expect_f("R2", 1, 2, 0);
      put(1'b1, NR, 4'd1, 4'd6);        // load gone, r6 in memory
      expect_f("R8", 0, 0, 1);
   endtask

   task automatic t_distance();
      do_reset();
      put(1'b1, 4'd2, NR, NR);
      put(1'b1, NR, NR, NR);
      expect_f("R5", 0, 0, 0);
      put(1'b1, NR, 4'd9, 4'd2);        // r2 producer in memory
      expect_f("R3", 0, 0, 1);
      put(1'b1, NR, 4'd2, NR);          // producer in writeback
      expect_f("R4", 0, 2, 0);
      put(1'b1, NR, 4'd2, 4'd2);        // producer retired
      expect_f("R5", 0, 0, 0);
   endtask

   task automatic t_youngest();
      do_reset();
      put(1'b1, 4'd5, NR, NR);
      put(1'b1, 4'd5, NR, NR);
      put(1'b1, NR, NR, NR);
      put(1'b1, NR, 4'd5, 4'd5);        // r5 in memory and writeback
      expect_f("R6", 0, 1, 1);
   endtask

   task automatic t_none_reg();
      do_reset();
      put(1'b1, NR, NR, NR);            // destination "no register"
      put(1'b1, 4'd3, NR, 4'd3);
      expect_f("R7", 0, 0, 0);
      put(1'b1, NR, NR, NR);            // r3 in execute, sources none
      expect_f("R7", 0, 0, 0);
      expect_n("R7", 0, 0, 0);
   endtask

   task automatic t_invalid();
      do_reset();
      put(1'b0, 4'd4, NR, NR);          // empty slot with a stray dest
      put(1'b1, 4'd7, 4'd4, NR);
      expect_f("R9", 0, 0, 0);
      put(1'b0, NR, 4'd7, 4'd7);        // empty slot matching execute
      expect_f("R9", 0, 0, 0);
      put(1'b1, NR, 4'd4, 4'd7);        // r7 now in memory
      expect_f("R9", 0, 0, 1);
   endtask

   task automatic t_no_bypass();
      do_reset();
      put(1'b1, 4'd1, NR, NR);
      put(1'b1, NR, 4'd1, NR);          // producer in execute
      expect_n("R10", 1, 0, 0);
      put(1'b1, NR, 4'd1, NR);          // memory
      expect_n("R10", 1, 0, 0);
      put(1'b1, NR, 4'd1, NR);          // writeback
      expect_n("R10", 1, 0, 0);
      put(1'b1, NR, 4'd1, NR);          // written back
      expect_n("R10", 0, 0, 0);
      put(1'b1, NR, NR, NR);
      expect_n("R10", 0, 0, 0);
   endtask

   initial begin
      #100000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_state();
      t_load_use();
      t_distance();
      t_youngest();
      t_none_reg();
      t_invalid();
      t_no_bypass();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule